// File: doc/BRIEF.md
# Parallel-Evaluate Selectable ALU

This block is the arithmetic and logic unit of a small register machine. It is purely combinational. It takes two operands and a 3-bit operation code, and returns one result word together with two condition flags.

All seven functions are computed side by side in every evaluation: add, subtract, AND, XOR, left shift, arithmetic right shift and copy of the second operand. A decoder turns the 3-bit code into one select line per function, and exactly one of those lines is raised. An AND-OR network then lets only the selected result reach the output.

The zero and positive flags are derived from that selected result. Branch logic elsewhere uses them.

Top module: `alu16_core`

## Requirements
- R1: Code 000 outputs `opa + opb`, truncated to the word width (wrap-around).
- R2: Code 001 outputs `opa - opb` in two's complement, truncated to the word width.
- R3: Code 010 outputs the bitwise AND of `opa` and `opb`.
- R4: Code 011 outputs the bitwise XOR of `opa` and `opb`.
- R5: Code 100 outputs `opa` shifted left by the unsigned value of `opb`, filling with zeros. Any amount of 16 or more gives 0x0000.
- R6: Code 101 outputs `opa` shifted right by the unsigned value of `opb`, filling with copies of bit 15. Any amount of 16 or more gives 0xFFFF when bit 15 of `opa` is set and 0x0000 when it is clear.
- R7: Codes 110 and 111 both output `opb` unchanged.
- R8: For every code exactly one internal function-select line is active, so no two function results are merged on the output.
- R9: `is_zero` is 1 exactly when `result` equals 0x0000.
- R10: `is_pos` is 1 exactly when bit 15 of `result` is 0 and `result` is nonzero. `is_zero` and `is_pos` are therefore never both 1.
- R11: The outputs follow any input change with no clock and no storage. The values seen after a change depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand; the value that is shifted |
| opb | input | 16 | Second operand; the shift amount; the value copied by codes 110/111 |
| op_code | input | 3 | Function code |
| result | output | 16 | Selected function result |
| is_zero | output | 1 | Result equals zero |
| is_pos | output | 1 | Result is nonzero with bit 15 clear |

## Verification
The two things that could appear together in one evaluation are two function results ORed onto the output through a double select line. A second such case is the two flags raised on the same word.

To provoke both, the bench sweeps all eight codes with operand pairs chosen so that the seven results differ from one another. It also drives zero, negative and saturating-shift operands.

Each output word is compared exactly with an independent model. Any merge of two results would show up as extra set bits. The flags are checked against the model result as a pair on every vector.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int NUM_FN  = 7;
  localparam int FN_ADD  = 0;
  localparam int FN_SUB  = 1;
  localparam int FN_AND  = 2;
  localparam int FN_XOR  = 3;
  localparam int FN_SHL  = 4;
  localparam int FN_SHR  = 5;
  localparam int FN_PASS = 6;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'b000,
    OPC_SUB   = 3'b001,
    OPC_AND   = 3'b010,
    OPC_XOR   = 3'b011,
    OPC_SHL   = 3'b100,
    OPC_SHR   = 3'b101,
    OPC_PASS  = 3'b110,
    OPC_PASS2 = 3'b111
  } opcode_e;

  typedef logic [NUM_FN-1:0] fn_sel_t;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [2:0] op_code,
  output fn_sel_t    fn_sel
);
  always_comb begin
    fn_sel = '0;
    case (opcode_e'(op_code))
      OPC_ADD:  fn_sel[FN_ADD]  = 1'b1;
      OPC_SUB:  fn_sel[FN_SUB]  = 1'b1;
      OPC_AND:  fn_sel[FN_AND]  = 1'b1;
      OPC_XOR:  fn_sel[FN_XOR]  = 1'b1;
      OPC_SHL:  fn_sel[FN_SHL]  = 1'b1;
      OPC_SHR:  fn_sel[FN_SHR]  = 1'b1;
      default:  fn_sel[FN_PASS] = 1'b1;
    endcase
  end

  // R8: a single select line per code
  always_comb begin
    if (!$isunknown(op_code))
      assert_sel_onehot_R8: assert ($countones(fn_sel) == 1)
        else $error("select lines not one-hot for code %b", op_code);
  end
endmodule

// File: rtl/alu16_units.sv
module alu16_units
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]             opa,
  input  logic [W-1:0]             opb,
  output logic [NUM_FN-1:0][W-1:0] fn_res,
  output logic                     shamt_sat
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + ~y + W'(1);
  endfunction

  function automatic logic [W-1:0] f_shl(input logic [W-1:0] x, input logic [SHW-1:0] n,
                                         input logic sat);
    return sat ? '0 : (x << n);
  endfunction

  function automatic logic [W-1:0] f_sra(input logic [W-1:0] x, input logic [SHW-1:0] n,
                                         input logic sat);
    return sat ? {W{x[W-1]}} : $unsigned($signed(x) >>> n);
  endfunction

  // any amount bit at or above log2(W) means the shift leaves the word
  assign shamt_sat = |opb[W-1:SHW];

  always_comb begin
    fn_res[FN_ADD]  = f_add(opa, opb);
    fn_res[FN_SUB]  = f_sub(opa, opb);
    fn_res[FN_AND]  = opa & opb;
    fn_res[FN_XOR]  = opa ^ opb;
    fn_res[FN_SHL]  = f_shl(opa, opb[SHW-1:0], shamt_sat);
    fn_res[FN_SHR]  = f_sra(opa, opb[SHW-1:0], shamt_sat);
    fn_res[FN_PASS] = opb;
  end

  // R5 / R6: saturated shifts
  always_comb begin
    if (!$isunknown({opa, opb}) && shamt_sat) begin
      assert_shl_sat_R5: assert (fn_res[FN_SHL] == '0)
        else $error("left shift not cleared on large amount");
      assert_shr_sat_R6: assert (fn_res[FN_SHR] == {W{opa[W-1]}})
        else $error("right shift not sign-filled on large amount");
    end
  end
endmodule

// File: rtl/alu16_select.sv
module alu16_select
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NUM_FN-1:0][W-1:0] fn_res,
  input  fn_sel_t                  fn_sel,
  output logic [W-1:0]             y
);
  logic [NUM_FN-1:0][W-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FN; gi++) begin : g_gate
      assign gated[gi] = fn_res[gi] & {W{fn_sel[gi]}};
    end
  endgenerate

  always_comb begin
    y = '0;
    for (int i = 0; i < NUM_FN; i++) y = y | gated[i];
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op_code,
  output logic [W-1:0] result,
  output logic         is_zero,
  output logic         is_pos
);
  fn_sel_t                  fn_sel;
  logic [NUM_FN-1:0][W-1:0] fn_res;
  logic                     shamt_sat;

  alu16_decode u_decode (
    .op_code (op_code),
    .fn_sel  (fn_sel)
  );

  alu16_units #(.W(W)) u_units (
    .opa       (opa),
    .opb       (opb),
    .fn_res    (fn_res),
    .shamt_sat (shamt_sat)
  );

  alu16_select #(.W(W)) u_select (
    .fn_res (fn_res),
    .fn_sel (fn_sel),
    .y      (result)
  );

  assign is_zero = (result == '0);
  assign is_pos  = ~result[W-1] & ~is_zero;

  always_comb begin
    if (!$isunknown({opa, opb, op_code})) begin
      assert_flags_excl_R10: assert (!(is_zero && is_pos))
        else $error("zero and positive flags both set");
      assert_pos_sign_R10: assert (!is_pos || !result[W-1])
        else $error("positive flag with sign bit set");
      if (op_code[2:1] == 2'b11)
        assert_pass_b_R7: assert (result == opb)
          else $error("pass code did not copy operand B");
      if (op_code == 3'b100 && shamt_sat)
        assert_shl_out_R5: assert (result == '0)
          else $error("left shift output not zero");
      if (op_code == 3'b010)
        assert_and_subset_R3: assert ((result & ~opa) == '0)
          else $error("AND result has bits outside operand A");
    end
  end
endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb;
  localparam int W = 16;
  localparam time HALF = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [2:0]   op_code = '0;
  logic [W-1:0] result;
  logic         is_zero, is_pos;

  int checks = 0;
  int errors = 0;

  always #HALF clk = ~clk;

  alu16_core #(.W(W)) u_dut (
    .opa(opa), .opb(opb), .op_code(op_code),
    .result(result), .is_zero(is_zero), .is_pos(is_pos)
  );

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // independent model, bit by bit where practical
  function automatic logic [W-1:0] model(input logic [2:0] c, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W-1:0] r;
    int unsigned amt;
    int unsigned wide;
    r   = '0;
    amt = b;
    case (c)
      3'd0: begin wide = a + b; r = wide[W-1:0]; end
      3'd1: begin wide = 32'h10000 + a - b; r = wide[W-1:0]; end
      3'd2: for (int i = 0; i < W; i++) r[i] = a[i] && b[i];
      3'd3: for (int i = 0; i < W; i++) r[i] = a[i] != b[i];
      3'd4: for (int i = 0; i < W; i++) r[i] = (i >= amt) ? a[i - amt] : 1'b0;
      3'd5: for (int i = 0; i < W; i++) r[i] = (i + amt >= W) ? a[W-1] : a[i + amt];
      default: r = b;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (code %b a %h b %h)", tag, got, exp, op_code, opa, opb);
    end
  endtask

  task automatic run(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] e;
    @(posedge clk);
    op_code = c; opa = a; opb = b;
    @(negedge clk);
    e = model(c, a, b);
    check(req_of(c), result, e);
    check("R9 zero flag", {15'd0, is_zero}, {15'd0, e == '0});
    check("R10 positive flag", {15'd0, is_pos}, {15'd0, (e != '0) && !e[W-1]});
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero inputs give add of zero
    check("R1 idle", result, 16'h0000);
    check("R9 idle zero", {15'd0, is_zero}, 16'd1);

    // R8: operands whose seven results all differ, every code
    for (int c = 0; c < 8; c++) run(3'(c), 16'h00F3, 16'h0005);
    // R1/R2 wrap
    run(3'd0, 16'hFFFF, 16'h0001);
    run(3'd1, 16'h0000, 16'h0001);
    run(3'd1, 16'h0028, 16'h0064);
    // R5/R6 boundaries
    run(3'd4, 16'h8001, 16'd15);
    run(3'd4, 16'hFFFF, 16'd16);
    run(3'd4, 16'h1234, 16'hFFFF);
    run(3'd5, 16'h8000, 16'd15);
    run(3'd5, 16'h8000, 16'd16);
    run(3'd5, 16'h7FFF, 16'd40);
    run(3'd5, 16'hF00F, 16'd0);
    // R7 both pass codes, R9/R10 flag corners
    run(3'd6, 16'hAAAA, 16'h0000);
    run(3'd7, 16'h5555, 16'h8000);
    run(3'd7, 16'h0000, 16'h7FFF);

    // R11: back-to-back changes, no clocked state
    for (int n = 0; n < 200; n++)
      for (int c = 0; c < 8; c++) begin
        logic [W-1:0] ra, rb;
        ra = W'($urandom);
        rb = W'($urandom);
        if ((c == 4 || c == 5) && ($urandom % 4 != 0)) rb = W'($urandom % 20);
        run(3'(c), ra, rb);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule